// File: doc/BRIEF.md
# Stop-and-Wait Shared Bus Arbiter

This block decides which of several multi-cycle operator units (move, compare, add, multiply, load/store) may use one shared 64-bit register-file bus. An operator that needs the bus raises its request line. When the bus is free, the arbiter answers with an acknowledge. The operator then keeps the bus for as many cycles as its chunk transfer takes, and gives it up only by dropping its request. The arbiter never preempts an owner and never times one out.

While any operator owns the bus, the block raises a busy output toward the host core, so that no new instruction is issued until the transfer ends. The block also drives the shared bus itself. It places the owner's 64-bit mantissa chunk, its header word and its valid bit on the bus. An idle bus carries zeros. A coprocessor uses two copies of this block: one guards the operand-read buses and the other guards the write-back bus. Each copy's busy output feeds the coprocessor's overall stall.

Top module: `stopwait_bus_arbiter`

## Requirements
- R1: During and directly after reset, every acknowledge is low, busy is low, and the bus chunk, header and valid outputs are zero, whatever the requests are.
- R2: A request on an idle bus is acknowledged one clock edge after it is first sampled high.
- R3: When several requests are present and the bus is free, the acknowledge goes to the requester with the lowest index (bit 0 of the request vector has the highest priority).
- R4: An owner whose request stays high keeps its acknowledge on every following edge. A request from any other operator, including a higher-priority one, is not acknowledged meanwhile.
- R5: An acknowledge falls on the first edge at which its request is sampled low. At that same edge, the lowest-index pending request, if there is one, is acknowledged, so ownership passes with no idle cycle.
- R6: At most one acknowledge is high at any time, and an acknowledge is only ever high for an operator whose request was high at the previous edge.
- R7: Busy is high exactly in the cycles in which some acknowledge is high.
- R8: The bus chunk, header and valid outputs equal the owner's inputs. The inputs of operators that do not own the bus have no effect on them.
- R9: While no acknowledge is held, the bus chunk and header are all zeros and bus valid is low, even when operators present non-zero data and valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_req | input | N_OPS | Bus request, one bit per operator (bit 0 highest priority) |
| op_chunk | input | N_OPS x CHUNK_W | Mantissa chunk offered by each operator |
| op_hdr | input | N_OPS x HDR_W | Header word offered by each operator |
| op_vld | input | N_OPS | Chunk-valid flag offered by each operator |
| op_ack | output | N_OPS | Bus grant, at most one bit high |
| host_busy | output | 1 | Stall toward the host while the bus is owned |
| bus_chunk | output | CHUNK_W | Shared bus chunk from the owner, zero when idle |
| bus_hdr | output | HDR_W | Shared bus header from the owner, zero when idle |
| bus_vld | output | 1 | Shared bus valid from the owner, low when idle |

## Verification
The hardest case to reach is the handover edge. At that edge the owner drops its request while a higher-priority operator and a lower-priority operator are both already waiting. The acknowledge must move at that same edge, and it must move to the waiter with the lowest index, not the one that asked first. The stimulus builds this state on purpose. An operator in the middle of the order takes the bus first. Operator 0 and a higher-numbered operator then raise requests while the owner holds on, and the bench checks over several edges that neither of them is granted. Only after that does the owner release. The bench also changes the chunk of an operator that does not own the bus while the bus is held, and checks that the bus output does not move.

// File: rtl/stopwait_arb_pkg.sv
// Package: default sizes shared by the arbiter and its submodules.
// Assumes: one chunk moves per cycle on the shared bus.
package stopwait_arb_pkg;
    localparam int unsigned CHUNK_W_DEF = 64;
    localparam int unsigned HDR_W_DEF   = 16;
    localparam int unsigned N_OPS_DEF   = 5;
endpackage

// File: rtl/arb_lowest_pick.sv
// Module: fixed-priority picker that returns the lowest set request as a one-hot vector.
// Assumes: bit 0 has the highest priority; purely combinational.
module arb_lowest_pick #(
    parameter int unsigned N = stopwait_arb_pkg::N_OPS_DEF
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick
);
    // below[i] is high when any request with index lower than i is set
    logic [N:0] below;

    assign below[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_pick
        assign below[i+1] = below[i] | req[i];
        assign pick[i]    = req[i] & ~below[i];
    end
endmodule

// File: rtl/arb_grant_hold.sv
// Module: grant register for the stop-and-wait protocol; a grant lasts until
// the owner withdraws its request, and then a new grant may be made at the same edge.
// Assumes: cand is one-hot or zero; synchronous active-low reset.
module arb_grant_hold #(
    parameter int unsigned N = stopwait_arb_pkg::N_OPS_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] cand,
    output logic [N-1:0] ack,
    output logic         busy
);
    logic [N-1:0] ack_q;
    logic [N-1:0] ack_d;
    logic         keep;

    // The owner keeps the bus while its request is still raised
    assign keep = |(ack_q & req);

    // Next grant: hold the current owner, else give the bus to the picked candidate
    always_comb begin
        if (keep) begin
            ack_d = ack_q;
        end else begin
            ack_d = cand;
        end
    end

    // Grant register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= '0;
        end else begin
            ack_q <= ack_d;
        end
    end

    assign ack  = ack_q;
    assign busy = |ack_q;
endmodule

// File: rtl/arb_bus_mux.sv
// Module: AND-OR multiplexer that puts the owner's chunk, header and valid on the bus.
// Assumes: sel is one-hot or zero; a zero sel gives an all-zero bus.
module arb_bus_mux #(
    parameter int unsigned N       = stopwait_arb_pkg::N_OPS_DEF,
    parameter int unsigned CHUNK_W = stopwait_arb_pkg::CHUNK_W_DEF,
    parameter int unsigned HDR_W   = stopwait_arb_pkg::HDR_W_DEF
) (
    input  logic [N-1:0]              sel,
    input  logic [N-1:0][CHUNK_W-1:0] in_chunk,
    input  logic [N-1:0][HDR_W-1:0]   in_hdr,
    input  logic [N-1:0]              in_vld,
    output logic [CHUNK_W-1:0]        out_chunk,
    output logic [HDR_W-1:0]          out_hdr,
    output logic                      out_vld
);
    // Partial OR chains, one stage per operator
    logic [N:0][CHUNK_W-1:0] acc_chunk;
    logic [N:0][HDR_W-1:0]   acc_hdr;

    assign acc_chunk[0] = '0;
    assign acc_hdr[0]   = '0;

    for (genvar i = 0; i < N; i++) begin : g_mux
        assign acc_chunk[i+1] = acc_chunk[i] | (in_chunk[i] & {CHUNK_W{sel[i]}});
        assign acc_hdr[i+1]   = acc_hdr[i]   | (in_hdr[i]   & {HDR_W{sel[i]}});
    end

    assign out_chunk = acc_chunk[N];
    assign out_hdr   = acc_hdr[N];
    assign out_vld   = |(in_vld & sel);
endmodule

// File: rtl/stopwait_bus_arbiter.sv
// Module: stop-and-wait arbiter for one shared register-file bus. It grants the bus
// to one operator at a time, holds the grant until the request is withdrawn, signals
// busy to the host while the bus is held, and multiplexes the owner's data onto the bus.
// Assumes: an operator keeps its request high for its whole transfer; synchronous active-low reset.
module stopwait_bus_arbiter #(
    parameter int unsigned N_OPS   = stopwait_arb_pkg::N_OPS_DEF,
    parameter int unsigned CHUNK_W = stopwait_arb_pkg::CHUNK_W_DEF,
    parameter int unsigned HDR_W   = stopwait_arb_pkg::HDR_W_DEF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_OPS-1:0]              op_req,
    input  logic [N_OPS-1:0][CHUNK_W-1:0] op_chunk,
    input  logic [N_OPS-1:0][HDR_W-1:0]   op_hdr,
    input  logic [N_OPS-1:0]              op_vld,
    output logic [N_OPS-1:0]              op_ack,
    output logic                          host_busy,
    output logic [CHUNK_W-1:0]            bus_chunk,
    output logic [HDR_W-1:0]              bus_hdr,
    output logic                          bus_vld
);
    logic [N_OPS-1:0] cand;
    logic [N_OPS-1:0] grant;

    arb_lowest_pick #(.N(N_OPS)) u_pick (
        .req  (op_req),
        .pick (cand)
    );

    arb_grant_hold #(.N(N_OPS)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (op_req),
        .cand  (cand),
        .ack   (grant),
        .busy  (host_busy)
    );

    arb_bus_mux #(.N(N_OPS), .CHUNK_W(CHUNK_W), .HDR_W(HDR_W)) u_mux (
        .sel       (grant),
        .in_chunk  (op_chunk),
        .in_hdr    (op_hdr),
        .in_vld    (op_vld),
        .out_chunk (bus_chunk),
        .out_hdr   (bus_hdr),
        .out_vld   (bus_vld)
    );

    assign op_ack = grant;
endmodule

// File: rtl/stopwait_bus_arbiter_chk.sv
// Module: protocol checker for the stop-and-wait arbiter, bound to the top module.
// Assumes: observes ports only.
module stopwait_bus_arbiter_chk #(
    parameter int unsigned N       = 5,
    parameter int unsigned CHUNK_W = 64,
    parameter int unsigned HDR_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N-1:0]       op_req,
    input logic [N-1:0]       op_ack,
    input logic               host_busy,
    input logic [CHUNK_W-1:0] bus_chunk,
    input logic [HDR_W-1:0]   bus_hdr,
    input logic               bus_vld
);
    // R6
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_ack));

    // R6
    ack_had_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_ack & ~$past(op_req)) == '0));

    // R4
    hold_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_ack & op_req) != '0) |=> (op_ack == $past(op_ack)));

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_ack & ~op_req) != '0) |=> ((op_ack & $past(op_ack)) == '0));

    // R3
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((op_ack & op_req) == '0) && (op_req != '0)) |=>
            ((op_ack != '0) && (((op_ack - 1'b1) & $past(op_req)) == '0)));

    // R7
    busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy == (op_ack != '0));

    // R9
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_busy |-> (bus_chunk == '0 && bus_hdr == '0 && !bus_vld));
endmodule

bind stopwait_bus_arbiter stopwait_bus_arbiter_chk #(
    .N(N_OPS), .CHUNK_W(CHUNK_W), .HDR_W(HDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_req    (op_req),
    .op_ack    (op_ack),
    .host_busy (host_busy),
    .bus_chunk (bus_chunk),
    .bus_hdr   (bus_hdr),
    .bus_vld   (bus_vld)
);

// File: tb/stopwait_bus_arbiter_tb.sv
module stopwait_bus_arbiter_tb;
    localparam int N = 5;
    localparam int CW = 64;
    localparam int HW = 16;
    localparam time CLK_PERIOD = 10ns;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N-1:0]         op_req = '0;
    logic [N-1:0][CW-1:0] op_chunk;
    logic [N-1:0][HW-1:0] op_hdr;
    logic [N-1:0]         op_vld = '0;
    logic [N-1:0]         op_ack;
    logic                 host_busy;
    logic [CW-1:0]        bus_chunk;
    logic [HW-1:0]        bus_hdr;
    logic                 bus_vld;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stopwait_bus_arbiter #(.N_OPS(N), .CHUNK_W(CW), .HDR_W(HW)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_req(op_req), .op_chunk(op_chunk),
        .op_hdr(op_hdr), .op_vld(op_vld), .op_ack(op_ack), .host_busy(host_busy),
        .bus_chunk(bus_chunk), .bus_hdr(bus_hdr), .bus_vld(bus_vld)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic load_data();
        for (int i = 0; i < N; i++) begin
            op_chunk[i] = 64'hA5A5_0000_0000_0000 + 64'(i) * 64'h1111;
            op_hdr[i]   = 16'hC000 + 16'(i);
        end
        op_vld = '1;
    endtask

    // R1: reset state with requests active
    task automatic t_reset();
        load_data();
        op_req = 5'b10110;
        step(); step();
        chk("R1 ack in reset", 128'(op_ack), 128'(0));
        chk("R1 busy in reset", 128'(host_busy), 128'(0));
        chk("R1 bus in reset", 128'({bus_chunk, bus_hdr, bus_vld}), 128'(0));
        op_req = '0;
        rst_n = 1'b1;
        step();
        chk("R1 ack after reset", 128'(op_ack), 128'(0));
    endtask

    // R2, R7, R8: single requester on idle bus
    task automatic t_single();
        op_req = 5'b00100;
        step();
        chk("R2 single grant", 128'(op_ack), 128'(5'b00100));
        chk("R7 busy with grant", 128'(host_busy), 128'(1));
        chk("R8 bus chunk from owner", 128'(bus_chunk), 128'(op_chunk[2]));
        chk("R8 bus hdr from owner", 128'(bus_hdr), 128'(op_hdr[2]));
        op_chunk[4] = 64'hDEAD_BEEF_0000_0001;
        op_hdr[3]   = 16'hFFFF;
        #1;
        chk("R8 non-owner data ignored", 128'({bus_chunk, bus_hdr}),
            128'({64'hA5A5_0000_0000_2222, 16'hC002}));
        op_vld[2] = 1'b0;
        #1;
        chk("R8 valid follows owner", 128'(bus_vld), 128'(0));
        op_vld[2] = 1'b1;
        op_req = '0;
        step();
        chk("R5 release to idle", 128'(op_ack), 128'(0));
        chk("R7 busy drops", 128'(host_busy), 128'(0));
    endtask

    // R3, R4, R5: priority, hold against higher priority, handover
    task automatic t_priority_hold_handover();
        op_req = 5'b11010;
        step();
        chk("R3 lowest index wins", 128'(op_ack), 128'(5'b00010));
        op_req = 5'b11011;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R4 owner holds, no preempt", 128'(op_ack), 128'(5'b00010));
        end
        op_req = 5'b11001;
        step();
        chk("R5 handover to lowest waiter", 128'(op_ack), 128'(5'b00001));
        chk("R7 busy through handover", 128'(host_busy), 128'(1));
        op_req = 5'b11000;
        step();
        chk("R5 second handover", 128'(op_ack), 128'(5'b01000));
        chk("R8 bus from new owner", 128'(bus_hdr), 128'(16'hFFFF));
    endtask

    // R9: idle bus with non-zero operator data
    task automatic t_idle();
        op_req = '0;
        op_vld = '1;
        step();
        chk("R9 idle chunk zero", 128'(bus_chunk), 128'(0));
        chk("R9 idle hdr and valid zero", 128'({bus_hdr, bus_vld}), 128'(0));
        chk("R6 no ack when idle", 128'(op_ack), 128'(0));
    endtask

    initial begin
        op_chunk = '0;
        op_hdr = '0;
        t_reset();
        t_single();
        t_priority_hold_handover();
        t_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule